// File: doc/BRIEF.md
# Interrupt Request Front End

This block sits between the raw interrupt and test pins of a small processor core and the core's sequencer. It brings a maskable request, a non-maskable request and a test input into the clock domain through two-flop synchronizers. The non-maskable input is edge sensitive: a low-to-high change is caught in a pending latch that stays set until the core acknowledges it. The maskable input is a plain level, looked at only when the core marks the last clock of an instruction and only while the core's interrupt-enable flag is set.

A small state machine makes the decision. It has four states: `ST_IDLE`, `ST_NMI_ACK`, `ST_INTA` and `ST_REPORT`. When `boundary_i` is high in `ST_IDLE`, a pending non-maskable request takes the *nmi_take* transition to `ST_NMI_ACK`. Without one, an enabled maskable request takes the *mask_take* transition to `ST_INTA`. In both of those states `take_o` is held high until the core raises `ack_i`. The *ack* transition then moves to `ST_REPORT`, where `vec_vld_o` pulses for one cycle with the interrupt type: the fixed value 2 for the non-maskable path, or the byte on `ext_type_i` sampled at the acknowledge for the maskable path. The *drain* transition returns to `ST_IDLE`.

Separately, `go_on_o` tells a wait-for-test instruction that it may proceed: it is high when the synchronized test input is low.

Top module: `irq_front_end`

## Requirements
- R1: During and right after reset, `take_o`, `vec_vld_o` and `go_on_o` are 0 and `type_o` is 8'h00.
- R2: `go_on_o` equals the inverse of the `test_n_i` value driven before the clock edge two edges earlier, so a low test input lets the wait instruction continue.
- R3: In `ST_IDLE`, a clock edge with `boundary_i`=1, `ien_i`=1 and a synchronized high `irq_lvl_i` makes `take_o` read 1 after that edge. The level must have been steady for two edges.
- R4: With `ien_i`=0, a high `irq_lvl_i` at a boundary leaves `take_o` at 0.
- R5: The maskable request is evaluated only on edges where `boundary_i`=1. A high level on any other edge, or a level that has gone low by the boundary, is not taken.
- R6: A rising edge on `nmi_edge_i` is held pending for any number of cycles and is taken at the next boundary whatever `ien_i` is. A pulse one clock long is enough.
- R7: When both requests are pending at a boundary, the non-maskable one is taken first and reported with `type_o`=8'h02. The maskable request is taken at a later boundary.
- R8: After `ack_i`=1 in `ST_INTA`, the next cycle shows `vec_vld_o`=1 and `type_o` equal to `ext_type_i` as sampled at the acknowledging edge.
- R9: The non-maskable request is edge triggered. It stays pending until acknowledged, and an input held high after the acknowledge does not cause a second take.
- R10: While `take_o` is 1 it stays 1 until `ack_i`. Further boundaries have no effect on it.
- R11: `vec_vld_o` is a single-cycle pulse, and `type_o` reads 8'h00 when `vec_vld_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lvl_i | input | 1 | Maskable request, active-high level, asynchronous |
| nmi_edge_i | input | 1 | Non-maskable request, rising-edge sensitive, asynchronous |
| test_n_i | input | 1 | Test input, low means proceed, asynchronous |
| ien_i | input | 1 | Core interrupt-enable flag |
| boundary_i | input | 1 | Core marks the last clock of an instruction |
| ack_i | input | 1 | Core acknowledges the outstanding take |
| ext_type_i | input | 8 | Type byte for maskable requests, sampled at the acknowledge |
| take_o | output | 1 | Interrupt to be taken, held until acknowledged |
| vec_vld_o | output | 1 | One-cycle strobe: `type_o` is valid |
| type_o | output | 8 | Interrupt type |
| go_on_o | output | 1 | Wait-for-test may continue |

## Verification
The checker watches several properties on every cycle: `take_o` is held until acknowledge, the report strobe is one cycle long and only follows an acknowledge, a take starts only on a boundary with an enabled request or a pending edge, the non-maskable report carries type 2, and the pending latch survives until it is cleared. The bench scenarios are needed for the rest. They cover the two-edge synchronizer latency on every input, the rule that a held non-maskable level does not retrigger, priority ordering with a maskable request left waiting, and the pass-through of the acknowledge-time type byte.

// File: rtl/irq_fe_pkg.sv
package irq_fe_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_NMI_ACK = 2'd1,
        ST_INTA    = 2'd2,
        ST_REPORT  = 2'd3
    } fe_state_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int   DEPTH   = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o,
    output logic q_pre_o
);
    logic [DEPTH-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {DEPTH{RST_VAL}};
        else        stg_q <= {stg_q[DEPTH-2:0], d_i};
    end

    assign q_o     = stg_q[DEPTH-1];
    assign q_pre_o = stg_q[DEPTH-2];
endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic newer_i,
    input  logic older_i,
    input  logic clr_i,
    output logic pend_o
);
    logic pend_q;
    logic rise_w;

    assign rise_w = newer_i & ~older_i;

    // A new edge in the same cycle as the clear keeps the latch set.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= (pend_q & ~clr_i) | rise_w;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/irq_ctrl_fsm.sv
module irq_ctrl_fsm
    import irq_fe_pkg::*;
#(
    parameter int               TYPE_W   = 8,
    parameter logic [TYPE_W-1:0] NMI_TYPE = 8'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary_i,
    input  logic              ack_i,
    input  logic              nmi_pend_i,
    input  logic              mreq_i,
    input  logic              ien_i,
    input  logic [TYPE_W-1:0] ext_type_i,
    output logic              take_o,
    output logic              vec_vld_o,
    output logic [TYPE_W-1:0] type_o,
    output logic              nmi_clr_o
);
    fe_state_t         state_q, state_d;
    logic [TYPE_W-1:0] vec_q, vec_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            vec_q   <= vec_d;
        end
    end

    always_comb begin
        state_d = state_q;
        vec_d   = vec_q;
        unique case (state_q)
            ST_IDLE: begin
                if (boundary_i) begin
                    if (nmi_pend_i)          state_d = ST_NMI_ACK;
                    else if (ien_i && mreq_i) state_d = ST_INTA;
                end
            end
            ST_NMI_ACK: begin
                if (ack_i) begin
                    state_d = ST_REPORT;
                    vec_d   = NMI_TYPE;
                end
            end
            ST_INTA: begin
                if (ack_i) begin
                    state_d = ST_REPORT;
                    vec_d   = ext_type_i;
                end
            end
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        take_o    = (state_q == ST_NMI_ACK) || (state_q == ST_INTA);
        vec_vld_o = (state_q == ST_REPORT);
        type_o    = (state_q == ST_REPORT) ? vec_q : '0;
        nmi_clr_o = (state_q == ST_NMI_ACK) && ack_i;
    end
endmodule

// File: rtl/irq_front_end.sv
module irq_front_end #(
    parameter int               SYNC_DEPTH = 2,
    parameter int               TYPE_W     = 8,
    parameter logic [TYPE_W-1:0] NMI_TYPE   = 8'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_lvl_i,
    input  logic              nmi_edge_i,
    input  logic              test_n_i,
    input  logic              ien_i,
    input  logic              boundary_i,
    input  logic              ack_i,
    input  logic [TYPE_W-1:0] ext_type_i,
    output logic              take_o,
    output logic              vec_vld_o,
    output logic [TYPE_W-1:0] type_o,
    output logic              go_on_o
);
    logic mreq_s, mreq_pre;
    logic nmi_s, nmi_pre;
    logic tst_s, tst_pre;
    logic nmi_pend, nmi_clr;

    irq_sync #(.DEPTH(SYNC_DEPTH), .RST_VAL(1'b0)) u_sync_mreq (
        .clk(clk), .rst_n(rst_n), .d_i(irq_lvl_i), .q_o(mreq_s), .q_pre_o(mreq_pre)
    );
    irq_sync #(.DEPTH(SYNC_DEPTH), .RST_VAL(1'b0)) u_sync_nmi (
        .clk(clk), .rst_n(rst_n), .d_i(nmi_edge_i), .q_o(nmi_s), .q_pre_o(nmi_pre)
    );
    irq_sync #(.DEPTH(SYNC_DEPTH), .RST_VAL(1'b1)) u_sync_tst (
        .clk(clk), .rst_n(rst_n), .d_i(test_n_i), .q_o(tst_s), .q_pre_o(tst_pre)
    );

    irq_edge_latch u_nmi_latch (
        .clk(clk), .rst_n(rst_n), .newer_i(nmi_pre), .older_i(nmi_s),
        .clr_i(nmi_clr), .pend_o(nmi_pend)
    );

    irq_ctrl_fsm #(.TYPE_W(TYPE_W), .NMI_TYPE(NMI_TYPE)) u_fsm (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .ack_i(ack_i),
        .nmi_pend_i(nmi_pend), .mreq_i(mreq_s), .ien_i(ien_i),
        .ext_type_i(ext_type_i), .take_o(take_o), .vec_vld_o(vec_vld_o),
        .type_o(type_o), .nmi_clr_o(nmi_clr)
    );

    assign go_on_o = ~tst_s;

    logic unused_w;
    assign unused_w = mreq_pre ^ tst_pre;
endmodule

// File: rtl/irq_front_end_chk.sv
module irq_front_end_chk #(
    parameter int               TYPE_W   = 8,
    parameter logic [TYPE_W-1:0] NMI_TYPE = 8'd2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              boundary_i,
    input logic              ien_i,
    input logic              ack_i,
    input logic              take_o,
    input logic              vec_vld_o,
    input logic [TYPE_W-1:0] type_o,
    input logic              mreq_s,
    input logic              nmi_pend,
    input logic              nmi_clr
);
    p_take_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        take_o && !ack_i |=> take_o);

    p_vld_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld_o |=> !vec_vld_o);

    p_vld_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld_o |-> $past(take_o && ack_i));

    p_take_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_o) |-> $past(boundary_i) && ($past(ien_i && mreq_s) || $past(nmi_pend)));

    p_nmi_type_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld_o && $past(nmi_clr) |-> type_o == NMI_TYPE);

    p_pend_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pend && !nmi_clr |=> nmi_pend);
endmodule

bind irq_front_end irq_front_end_chk #(.TYPE_W(TYPE_W), .NMI_TYPE(NMI_TYPE)) chk_i (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .ien_i(ien_i),
    .ack_i(ack_i), .take_o(take_o), .vec_vld_o(vec_vld_o), .type_o(type_o),
    .mreq_s(mreq_s), .nmi_pend(nmi_pend), .nmi_clr(nmi_clr)
);

// File: tb/irq_front_end_tb.sv
`timescale 1ns/1ps
module irq_front_end_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_lvl_i = 1'b0, nmi_edge_i = 1'b0, test_n_i = 1'b1;
    logic       ien_i = 1'b0, boundary_i = 1'b0, ack_i = 1'b0;
    logic [7:0] ext_type_i = 8'h00;
    logic       take_o, vec_vld_o, go_on_o;
    logic [7:0] type_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_front_end dut_i (
        .clk(clk), .rst_n(rst_n), .irq_lvl_i(irq_lvl_i), .nmi_edge_i(nmi_edge_i),
        .test_n_i(test_n_i), .ien_i(ien_i), .boundary_i(boundary_i), .ack_i(ack_i),
        .ext_type_i(ext_type_i), .take_o(take_o), .vec_vld_o(vec_vld_o),
        .type_o(type_o), .go_on_o(go_on_o)
    );

    // {ien, level, boundary, expected take}
    localparam logic [3:0] MVEC [6] = '{
        4'b1111, 4'b0110, 4'b1010, 4'b1100, 4'b0010, 4'b0100
    };
    localparam logic [11:0] TPAT = 12'b1011_0010_0110;

    task automatic tick(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic ack_pulse(input logic [7:0] t);
        ext_type_i = t;
        ack_i = 1'b1;
        tick();
        ack_i = 1'b0;
        ext_type_i = 8'h00;
    endtask

    initial begin
        #2;
        tick(2);
        chk("R1 take", take_o, 0);
        chk("R1 vld", vec_vld_o, 0);
        chk("R1 type", type_o, 0);
        chk("R1 go_on", go_on_o, 0);
        rst_n = 1'b1;
        tick();
        chk("R1 take after release", take_o, 0);
        chk("R1 go_on after release", go_on_o, 0);

        // Vector table: maskable decision, R3 R4 R5
        for (int i = 0; i < 6; i++) begin
            ien_i = MVEC[i][3];
            irq_lvl_i = MVEC[i][2];
            tick(3);
            boundary_i = MVEC[i][1];
            tick();
            boundary_i = 1'b0;
            chk($sformatf("R3/R4/R5 vector %0d take", i), take_o, MVEC[i][0]);
            if (take_o) begin
                ack_pulse(8'h10 + 8'(i));
                chk("R8 table vld", vec_vld_o, 1);
                chk("R8 table type", type_o, 8'h10 + i);
                tick();
            end
            irq_lvl_i = 1'b0;
            ien_i = 1'b0;
            tick(3);
        end

        // R5: level gone before boundary
        ien_i = 1'b1; irq_lvl_i = 1'b1; tick(3);
        irq_lvl_i = 1'b0; tick(3);
        boundary_i = 1'b1; tick(); boundary_i = 1'b0;
        chk("R5 dropped level", take_o, 0);
        ien_i = 1'b0;

        // R6: single-clock pulse, long wait, ien low
        nmi_edge_i = 1'b1; tick(); nmi_edge_i = 1'b0;
        tick(20);
        chk("R6 no take before boundary", take_o, 0);
        boundary_i = 1'b1; tick(); boundary_i = 1'b0;
        chk("R6 take", take_o, 1);
        ack_pulse(8'h77);
        chk("R7 nmi vld", vec_vld_o, 1);
        chk("R7 nmi type", type_o, 2);
        tick();
        chk("R11 vld drops", vec_vld_o, 0);
        chk("R11 type zero", type_o, 0);

        // R7 priority, then R10 and R8
        ien_i = 1'b1; irq_lvl_i = 1'b1; nmi_edge_i = 1'b1;
        tick(); nmi_edge_i = 1'b0; tick(3);
        boundary_i = 1'b1; tick(); boundary_i = 1'b0;
        chk("R7 both take", take_o, 1);
        ack_pulse(8'h33);
        chk("R7 priority type", type_o, 2);
        tick();
        boundary_i = 1'b1; tick();
        chk("R7 maskable later", take_o, 1);
        tick(2); boundary_i = 1'b0; tick();
        chk("R10 held without ack", take_o, 1);
        chk("R10 no report", vec_vld_o, 0);
        ack_pulse(8'hA5);
        chk("R8 take cleared", take_o, 0);
        chk("R8 vld", vec_vld_o, 1);
        chk("R8 type", type_o, 8'hA5);
        tick();
        irq_lvl_i = 1'b0; ien_i = 1'b0; tick(3);

        // R9: held high does not retrigger
        nmi_edge_i = 1'b1; tick(3);
        boundary_i = 1'b1; tick(); boundary_i = 1'b0;
        chk("R9 first take", take_o, 1);
        ack_pulse(8'h00);
        tick(3);
        boundary_i = 1'b1; tick(); boundary_i = 1'b0;
        chk("R9 no retrigger", take_o, 0);
        nmi_edge_i = 1'b0; tick(3);

        // R2: test input pattern
        for (int i = 0; i < 12; i++) begin
            test_n_i = TPAT[i];
            tick();
            if (i >= 1) chk($sformatf("R2 go_on step %0d", i), go_on_o, !TPAT[i-1]);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule